// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Front End

This block sits behind the serial pins of a flash device and recognises the three block-erase commands. It oversamples the serial clock, chip select and data-in lines with the system clock. It shifts in a command byte and three address bytes, most significant bit first, and waits for chip select to rise before it acts. If the frame is well formed and the write-enable latch is set, it offers an erase request downstream. The request carries the block base address, with the low address bits for the chosen block size cleared, and a 2-bit size code.

The request leaves on a valid/ready stream. `req_valid` stays high, with `req_base` and `req_size` unchanged, until the cycle in which `req_ready` is also high. Back-pressure lasts as long as the consumer needs. While a request is waiting, or during the self-timed erase that follows acceptance, `busy` is high and the block ignores new frames. The erase lasts `ERASE_CYCLES` system clocks after the handshake. When it ends, `busy` falls and the write-enable latch clears. A malformed erase frame also clears the latch, and no request is raised.

Top module: `spi_erase_front`

## Requirements
- R1: Command byte 0x20 gives size code 0 (4 KB), 0x52 gives code 1 (32 KB) and 0xD8 gives code 2 (64 KB). Code 3 never appears on `req_size`.
- R2: `req_base` is the captured address with bits [11:0] cleared for code 0, bits [14:0] cleared for code 1, and bits [15:0] cleared for code 2.
- R3: An erase frame raises a request only if `wel` is 1 when the frame ends. With `wel` at 0 the frame has no effect. `wel_set` sets `wel` while the block is idle.
- R4: Data-in is sampled on rising serial clock, MSB first. The first byte is the command and the next three bytes are the address, high byte first. Any later bytes are ignored.
- R5: A request is raised only when chip select rises. `req_valid` goes high on the third system-clock edge after chip select is seen high.
- R6: An erase frame that ends with fewer than 32 bits, or with a bit count that is not a multiple of 8, raises no request and clears `wel`.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_base` and `req_size` hold.
- R8: `busy` is high from the cycle the request is raised until `ERASE_CYCLES` cycles after the handshake. `wel` clears in the same cycle that `busy` falls.
- R9: A frame that ends while `busy` is high has no effect.
- R10: A frame with any other command byte, or with fewer than 8 bits, has no effect and leaves `wel` unchanged.
- R11: After reset `req_valid`, `busy` and `wel` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, asynchronous to clk |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| wel_set | input | 1 | Pulse that sets the write-enable latch |
| req_ready | input | 1 | Consumer accepts the erase request |
| req_valid | output | 1 | Erase request offered |
| req_base | output | ADDR_W | Aligned block base address |
| req_size | output | 2 | Block size code |
| busy | output | 1 | Request pending or erase in progress |
| wel | output | 1 | Write-enable latch state |

## Verification
The bench uses a 24-bit address, two synchroniser stages and an erase length of 400 cycles. This erase length keeps the run short but is longer than a full 32-bit frame at the bench's serial rate, so a second erase frame can end inside the busy window and the ignore rule can be tested. With two synchroniser stages the request latency is fixed at three edges, and the bench model predicts the outputs cycle by cycle from that.

// File: rtl/blk_erase_pkg.sv
package blk_erase_pkg;
  typedef enum logic [1:0] {
    SZ_4K  = 2'd0,
    SZ_32K = 2'd1,
    SZ_64K = 2'd2
  } erase_size_e;

  localparam logic [7:0] OP_ER_4K  = 8'h20;
  localparam logic [7:0] OP_ER_32K = 8'h52;
  localparam logic [7:0] OP_ER_64K = 8'hD8;

  // number of low address bits dropped for each block size
  function automatic logic [4:0] drop_bits(erase_size_e s);
    case (s)
      SZ_32K:  return 5'd15;
      SZ_64K:  return 5'd16;
      default: return 5'd12;
    endcase
  endfunction
endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic csn_in,
  input  logic mosi_in,
  output logic sclk_rise,
  output logic cs_rise,
  output logic cs_high,
  output logic mosi_s
);
  // bit 2 = sclk, bit 1 = csn, bit 0 = mosi
  localparam logic [2:0] IDLE_V = 3'b010;
  logic [2:0] chain [STAGES];
  logic       sclk_d, csn_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= IDLE_V;
        else        chain[g] <= {sclk_in, csn_in, mosi_in};
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= IDLE_V;
        else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= chain[STAGES-1][2];
      csn_d  <= chain[STAGES-1][1];
    end

  assign sclk_rise = chain[STAGES-1][2] & ~sclk_d;
  assign cs_high   = chain[STAGES-1][1];
  assign cs_rise   = chain[STAGES-1][1] & ~csn_d;
  assign mosi_s    = chain[STAGES-1][0];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_idle,
  input  logic              bit_strobe,
  input  logic              bit_val,
  output logic [7:0]        opcode,
  output logic [ADDR_W-1:0] addr,
  output logic              whole
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int LAST       = ADDR_BYTES + 1;
  localparam int CNT_W      = $clog2(LAST + 1);

  logic [6:0]       shreg;
  logic [2:0]       bitcnt;
  logic [CNT_W-1:0] bytecnt;
  logic [7:0]       byte_now;

  assign byte_now = {shreg, bit_val};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      bitcnt  <= '0;
      bytecnt <= '0;
      opcode  <= '0;
      addr    <= '0;
    end else if (frame_idle) begin
      bitcnt  <= '0;
      bytecnt <= '0;
      opcode  <= '0;
    end else if (bit_strobe) begin
      shreg  <= byte_now[6:0];
      bitcnt <= bitcnt + 3'd1;
      if (bitcnt == 3'd7) begin
        if (bytecnt == '0)
          opcode <= byte_now;
        else if (bytecnt <= CNT_W'(ADDR_BYTES))
          addr <= {addr[ADDR_W-9:0], byte_now};
        if (bytecnt != CNT_W'(LAST))
          bytecnt <= bytecnt + 1'b1;
      end
    end

  assign whole = (bytecnt == CNT_W'(LAST)) && (bitcnt == 3'd0);
endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import blk_erase_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int ERASE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              whole,
  input  logic              wel_set,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_base,
  output logic [1:0]        req_size,
  output logic              busy,
  output logic              wel
);
  localparam int CW = $clog2(ERASE_CYCLES + 1);

  logic              erasing;
  logic [CW-1:0]     cnt;
  logic              is_erase;
  erase_size_e       dec_size;
  logic [ADDR_W-1:0] lowmask;
  logic              idle;

  always_comb begin
    is_erase = 1'b1;
    dec_size = SZ_4K;
    case (opcode)
      OP_ER_4K:  dec_size = SZ_4K;
      OP_ER_32K: dec_size = SZ_32K;
      OP_ER_64K: dec_size = SZ_64K;
      default:   is_erase = 1'b0;
    endcase
  end

  assign lowmask = (ADDR_W'(1) << drop_bits(dec_size)) - ADDR_W'(1);
  assign idle    = !req_valid && !erasing;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_base  <= '0;
      req_size  <= '0;
      erasing   <= 1'b0;
      cnt       <= '0;
      wel       <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        erasing   <= 1'b1;
        cnt       <= CW'(ERASE_CYCLES - 1);
      end
      if (erasing) begin
        if (cnt == '0) begin
          erasing <= 1'b0;
          wel     <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (frame_end && is_erase && wel && idle) begin
        if (whole) begin
          req_valid <= 1'b1;
          req_base  <= addr & ~lowmask;
          req_size  <= dec_size;
        end else begin
          wel <= 1'b0;
        end
      end else if (wel_set && idle) begin
        wel <= 1'b1;
      end
    end

  assign busy = req_valid | erasing;
endmodule

// File: rtl/spi_erase_front.sv
module spi_erase_front #(
  parameter int ADDR_W       = 24,
  parameter int ERASE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  input  logic              wel_set,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_base,
  output logic [1:0]        req_size,
  output logic              busy,
  output logic              wel
);
  logic              sclk_rise, cs_rise, cs_high, mosi_s;
  logic [7:0]        opcode;
  logic [ADDR_W-1:0] addr;
  logic              whole;

  spi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_in(spi_sclk), .csn_in(spi_csn), .mosi_in(spi_mosi),
    .sclk_rise(sclk_rise), .cs_rise(cs_rise), .cs_high(cs_high), .mosi_s(mosi_s)
  );

  frame_shifter #(.ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .frame_idle(cs_high), .bit_strobe(sclk_rise), .bit_val(mosi_s),
    .opcode(opcode), .addr(addr), .whole(whole)
  );

  erase_ctrl #(.ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .frame_end(cs_rise), .opcode(opcode), .addr(addr), .whole(whole),
    .wel_set(wel_set), .req_ready(req_ready),
    .req_valid(req_valid), .req_base(req_base), .req_size(req_size),
    .busy(busy), .wel(wel)
  );
endmodule

// File: rtl/spi_erase_front_chk.sv
module spi_erase_front_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_base,
  input logic [1:0]        req_size,
  input logic              busy,
  input logic              wel
);
  p_size_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_size != 2'd3);

  p_align_4k_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'd0 |-> req_base[11:0] == 12'd0);

  p_align_32k_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'd1 |-> req_base[14:0] == 15'd0);

  p_align_64k_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'd2 |-> req_base[15:0] == 16'd0);

  p_wel_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> wel);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_base) && $stable(req_size));

  p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  p_wel_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
endmodule

bind spi_erase_front spi_erase_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_base(req_base), .req_size(req_size), .busy(busy), .wel(wel)
);

// File: tb/sim_spi_erase_front.sv
module sim_spi_erase_front;
  localparam int AW = 24;
  localparam int EC = 400;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic wel_set = 1'b0, rdy = 1'b0;
  logic req_valid, busy, wel;
  logic [AW-1:0] req_base;
  logic [1:0] req_size;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_erase_front #(.ADDR_W(AW), .ERASE_CYCLES(EC), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .wel_set(wel_set), .req_ready(rdy), .req_valid(req_valid),
    .req_base(req_base), .req_size(req_size), .busy(busy), .wel(wel)
  );

  // ---------------- behavioural reference model ----------------
  int       fr_nbits = 0;
  logic [7:0]    fr_op = 8'h00;
  logic [AW-1:0] fr_addr = '0;
  logic h0 = 1, h1 = 1, h2 = 1, h3 = 1;
  logic m_pend = 0, m_wel = 0;
  int   m_rem = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_size = 2'd0;
  int   accepted = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = 1; h1 = 1; h2 = 1; h3 = 1;
      m_pend = 0; m_wel = 0; m_rem = 0;
    end else begin
      logic idle, ev, n_pend, n_wel, known;
      int n_rem, drop;
      logic [1:0] sz;
      h3 = h2; h2 = h1; h1 = h0; h0 = csn;
      ev = h2 & ~h3;
      idle = !m_pend && m_rem == 0;
      n_pend = m_pend; n_wel = m_wel; n_rem = m_rem;
      if (m_pend && rdy) begin n_pend = 0; n_rem = EC; accepted++; end
      if (m_rem > 0) begin
        n_rem = m_rem - 1;
        if (n_rem == 0) n_wel = 0;
      end
      known = 1; sz = 0; drop = 12;
      if (fr_op == 8'h20) begin sz = 0; drop = 12; end
      else if (fr_op == 8'h52) begin sz = 1; drop = 15; end
      else if (fr_op == 8'hD8) begin sz = 2; drop = 16; end
      else known = 0;
      if (ev && fr_nbits >= 8 && known && m_wel && idle) begin
        if (fr_nbits >= 32 && fr_nbits % 8 == 0) begin
          n_pend = 1; m_size = sz;
          m_base = (fr_addr >> drop) << drop;
        end else n_wel = 0;
      end else if (wel_set && idle) n_wel = 1;
      m_pend = n_pend; m_wel = n_wel; m_rem = n_rem;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cycles++;
    if (rst_n) begin
      chk("R5 req_valid", 32'(req_valid), 32'(m_pend));
      chk("R8 busy", 32'(busy), 32'(m_pend || m_rem > 0));
      chk("R3 wel", 32'(wel), 32'(m_wel));
      if (m_pend) begin
        chk("R2 req_base", 32'(req_base), 32'(m_base));
        chk("R1 req_size", 32'(req_size), 32'(m_size));
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // data is left aligned: bit 47 goes first (R4: MSB first)
  task automatic send(input logic [47:0] data, input int nbits);
    @(negedge clk); csn = 1'b0;
    idle_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = data[47-i];
      idle_clk(HALF); sclk = 1'b1;
      idle_clk(HALF); sclk = 1'b0;
    end
    idle_clk(HALF);
    fr_nbits = nbits; fr_op = data[47:40]; fr_addr = data[39:16];
    csn = 1'b1;
    idle_clk(8);
  endtask

  task automatic pulse_wel;
    @(negedge clk); wel_set = 1'b1;
    @(negedge clk); wel_set = 1'b0;
  endtask

  task automatic wait_free;
    while (busy) @(negedge clk);
    idle_clk(3);
  endtask

  initial begin
    idle_clk(3);
    // R11: reset state
    chk("R11 valid in reset", 32'(req_valid), 0);
    chk("R11 busy in reset", 32'(busy), 0);
    chk("R11 wel in reset", 32'(wel), 0);
    rst_n = 1'b1;
    idle_clk(2);

    // R3: erase without write enable has no effect
    send({8'h20, 24'h123ABC, 16'h0}, 32);
    chk("R3 no request without wel", 32'(accepted), 0);

    // R1 R2 R5: 4 KB erase, ready held high
    rdy = 1'b1;
    pulse_wel;
    send({8'h20, 24'h123ABC, 16'h0}, 32);
    wait_free;
    chk("R1 4K accepted", 32'(accepted), 1);

    // R4 R7: 32 KB with an extra trailing byte, back-pressure first
    rdy = 1'b0;
    pulse_wel;
    send({8'h52, 24'h12FFFF, 8'h55, 8'h0}, 40);
    idle_clk(20);
    chk("R7 still pending", 32'(req_valid), 1);
    rdy = 1'b1;
    wait_free;
    chk("R4 32K accepted", 32'(accepted), 2);

    // R1 R2: 64 KB
    pulse_wel;
    send({8'hD8, 24'hABCDEF, 16'h0}, 32);
    wait_free;
    chk("R2 64K accepted", 32'(accepted), 3);

    // R6: ragged frame and short frame abort, wel cleared
    pulse_wel;
    send({8'h20, 24'h777777, 16'h0}, 30);
    chk("R6 ragged abort wel", 32'(wel), 0);
    pulse_wel;
    send({8'h52, 24'h777777, 16'h0}, 24);
    chk("R6 short abort wel", 32'(wel), 0);
    pulse_wel;
    send({8'hD8, 24'h777777, 16'h0}, 33);
    chk("R6 odd abort wel", 32'(wel), 0);
    chk("R6 no requests", 32'(accepted), 3);

    // R10: other command and sub-byte frame leave wel set
    pulse_wel;
    send({8'h03, 24'h000100, 16'h0}, 32);
    chk("R10 other opcode wel", 32'(wel), 1);
    send({8'h20, 40'h0}, 5);
    chk("R10 sub-byte wel", 32'(wel), 1);
    chk("R10 no requests", 32'(accepted), 3);

    // R9: second erase frame ends while busy and is dropped
    send({8'h20, 24'h400000, 16'h0}, 32);
    send({8'hD8, 24'h510000, 16'h0}, 32);
    chk("R9 busy during second frame end", 32'(busy), 1);
    wait_free;
    chk("R9 only one accepted", 32'(accepted), 4);
    chk("R8 wel cleared after erase", 32'(wel), 0);

    idle_clk(5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule